// File: doc/BRIEF.md
# Stack frame address generator

This block forms the effective address for the three stack-frame operand modes of a small CPU core whose stack pointer and index registers are 16 bits wide. The sequencer pulses `start` with a mode code, the instruction's 8-bit operand byte, and the current S, X and Y values. The block answers with a 16-bit address, a one-clock `done` strobe, and a code that says which mode produced the address. The ALU operation that later uses the address is outside this block. That operation may be OR, AND, XOR, add-with-carry, store, load, compare or subtract-with-borrow.

Stack-relative mode counts upward from the top element of the stack, and an operand of zero reaches that top element. Base-relative mode treats X as a frame pointer and adds a signed displacement. Parameters, the return address and the saved link lie at positive displacements, and locals lie at negative ones. The indirect mode first forms the same frame address. It fetches a two-byte little-endian pointer from memory through a request/valid read port, then adds Y to that pointer. Every sum wraps at 16 bits.

Top module: `frame_agen`

## Requirements
- R1: Mode code 01 (base-relative) yields `ea` = X + operand sign-extended to 16 bits, so the displacement range is -128..+127.
- R2: Mode code 00 (stack-relative) yields `ea` = S + 1 + operand taken as unsigned, so operand 0 addresses the top stacked element.
- R3: Mode code 10 (indirect) forms B = X + sign-extended operand. It reads the low pointer byte at B and then the high byte at B + 1, and yields `ea` = {high, low} + Y.
- R4: All sums wrap modulo 65536. This includes the high-byte address B + 1 when B is 0xFFFF.
- R5: For a direct mode (00 or 01), `done` rises in the clock that follows the accepting edge.
- R6: During an indirect sequence, `rd_req` stays high and `rd_addr` stays stable until `rd_valid` is seen. `rd_valid` is ignored while no read is pending.
- R7: A `start` is ignored while a read is pending or while `done` is high. A `start` with mode code 11 is always ignored.
- R8: `done` lasts exactly one clock. `ea` and `kind` change only with `done` and then hold until the next completion.
- R9: S, X, Y and the operand are captured at the accepting edge, so later changes on those inputs do not alter the result.
- R10: A synchronous active-high `rst` returns the block to idle with `done`, `rd_req`, `ea` and `kind` all zero, even in the middle of a read.
- R11: `kind` reports the mode code of the request whose result is on `ea`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse |
| mode | input | 2 | 00 stack-relative, 01 base-relative, 10 indirect, 11 reserved |
| opnd | input | 8 | Operand byte (displacement) |
| sp_in | input | 16 | Stack pointer |
| xr_in | input | 16 | X register (frame base) |
| yr_in | input | 16 | Y register (post-index) |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data byte |
| ea | output | 16 | Effective address |
| done | output | 1 | One-clock completion strobe |
| kind | output | 2 | Mode code of the result on `ea` |

## Verification
A wrong sequencing state appears at the port in the same clock. `rd_req` would be high or low at the wrong time, or `rd_addr` would point at B where it should point at B + 1. A bad captured base or Y shows only when the request completes, as a wrong `ea` in the clock that carries `done`. A fault in the busy handling shows as a stray or missing `done` one clock after the ignored `start`. The bench compares every output on every clock, so each of these is caught within one clock of the point where it becomes visible.

// File: rtl/frame_agen.sv
module frame_agen #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] opnd,
  input  logic [AW-1:0] sp_in,
  input  logic [AW-1:0] xr_in,
  input  logic [AW-1:0] yr_in,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ea,
  output logic          done,
  output logic [1:0]    kind
);
  localparam logic [1:0] M_STK = 2'b00, M_BASE = 2'b01, M_IND = 2'b10, M_RSV = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;
  st_t st;

  logic [AW-1:0] base_q, yoff_q;
  logic [DW-1:0] lo_q;

  wire [AW-1:0] disp    = {{(AW-DW){opnd[DW-1]}}, opnd};
  wire [AW-1:0] frame_a = xr_in + disp;
  wire [AW-1:0] stack_a = sp_in + {{(AW-1){1'b0}}, 1'b1} + {{(AW-DW){1'b0}}, opnd};
  wire          accept  = start && (st == S_IDLE) && !done && (mode != M_RSV);

  assign rd_req  = (st != S_IDLE);
  assign rd_addr = (st == S_HI) ? base_q + {{(AW-1){1'b0}}, 1'b1} : base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      ea     <= '0;
      kind   <= M_STK;
      base_q <= '0;
      yoff_q <= '0;
      lo_q   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (mode == M_IND) begin
            base_q <= frame_a;
            yoff_q <= yr_in;
            st     <= S_LO;
          end else begin
            ea   <= (mode == M_STK) ? stack_a : frame_a;
            kind <= mode;
            done <= 1'b1;
          end
        end
        S_LO: if (rd_valid) begin
          lo_q <= rd_data;
          st   <= S_HI;
        end
        S_HI: if (rd_valid) begin
          ea   <= {rd_data, lo_q} + yoff_q;
          kind <= M_IND;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_ea_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!done && $past(!rst)) |-> ($stable(ea) && $stable(kind)));

  assert_rd_wait_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_rsv_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (start && mode == M_RSV && !rd_req && !done) |=> !done);

  assert_busy_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (start && done) |=> !done);

  assert_hi_follows_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_LO && rd_valid) |=> (rd_req && rd_addr == $past(rd_addr) + 16'd1));

  assert_done_direct_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !rd_req && !done && (mode == M_STK || mode == M_BASE)) |=> done);
endmodule

// File: tb/frame_agen_tb.sv
module frame_agen_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, start, rd_valid;
  logic [1:0] mode;
  logic [7:0] opnd, rd_data;
  logic [15:0] sp_in, xr_in, yr_in;
  logic rd_req, done;
  logic [15:0] rd_addr, ea;
  logic [1:0] kind;

  frame_agen dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .opnd(opnd),
    .sp_in(sp_in), .xr_in(xr_in), .yr_in(yr_in),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .ea(ea), .done(done), .kind(kind)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int phase = 0, mem_lat = 0, mem_wait = 0;
  bit spurious = 0;
  int e_ea = 0, e_kind = 0, m_base = 0, m_y = 0, m_lo = 0;
  bit e_done = 0;

  function automatic logic [7:0] memb(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    chk("R5/R8 done", int'(done), int'(e_done));
    chk("R1/R2/R3/R4/R9 ea", int'(ea), e_ea);
    chk("R11 kind", int'(kind), e_kind);
    chk("R6 rd_req", int'(rd_req), (phase != 0) ? 1 : 0);
    if (phase != 0)
      chk("R3/R4 rd_addr", int'(rd_addr), (phase == 1) ? m_base : ((m_base + 1) & 16'hFFFF));
  endtask

  // one clock: compare, drive, then advance the reference model
  task automatic tick(input bit st, input int md, input int op, input int s, input int x, input int y);
    @(negedge clk);
    compare_all();
    start = st; mode = md[1:0]; opnd = op[7:0];
    sp_in = s[15:0]; xr_in = x[15:0]; yr_in = y[15:0];
    if (rd_req) begin
      if (mem_wait == 0) begin
        rd_valid = 1'b1; rd_data = memb(rd_addr); mem_wait = mem_lat;
      end else begin
        rd_valid = 1'b0; rd_data = 8'hEE; mem_wait--;
      end
    end else begin
      rd_valid = spurious; rd_data = 8'h77; mem_wait = mem_lat;
    end
    begin
      bit nd = 0;
      int sx = (op & 8'h80) ? (op | 32'hFFFFFF00) : op;
      if (phase == 0) begin
        if (st && !e_done && md != 3) begin
          if (md == 2) begin
            m_base = (x + sx) & 16'hFFFF; m_y = y; phase = 1;
          end else begin
            e_ea = (md == 0) ? ((s + 1 + op) & 16'hFFFF) : ((x + sx) & 16'hFFFF);
            e_kind = md; nd = 1;
          end
        end
      end else if (rd_valid) begin
        if (phase == 1) begin
          m_lo = rd_data; phase = 2;
        end else begin
          e_ea = ((int'(rd_data) * 256 + m_lo) + m_y) & 16'hFFFF;
          e_kind = 2; nd = 1; phase = 0;
        end
      end
      e_done = nd;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 16'h1111, 16'h2222, 16'h3333);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; rd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    phase = 0; e_done = 0; e_ea = 0; e_kind = 0; m_base = 0; mem_wait = mem_lat;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 0; mode = 0; opnd = 0; sp_in = 0; xr_in = 0; yr_in = 0;
    rd_valid = 0; rd_data = 0;
    do_reset();
    idle(1);  // R10 reset state
    // R1 base-relative, positive and negative displacements
    tick(1, 1, 8'h05, 0, 16'h1000, 0); idle(2);
    tick(1, 1, 8'h80, 0, 16'h1000, 0); idle(2);
    tick(1, 1, 8'h7F, 0, 16'h01F0, 0); idle(2);
    // R4 base-relative wrap both ways
    tick(1, 1, 8'hF0, 0, 16'h0005, 0); idle(2);
    tick(1, 1, 8'h10, 0, 16'hFFF8, 0); idle(2);
    // R2 stack-relative zero-based, plus R4 wrap
    tick(1, 0, 8'h00, 16'h01FF, 0, 0); idle(2);
    tick(1, 0, 8'hFF, 16'h01F0, 0, 0); idle(2);
    tick(1, 0, 8'hFF, 16'hFFFF, 0, 0); idle(2);
    // R7 back-to-back: second start lands on done cycle and is ignored
    tick(1, 1, 8'h02, 0, 16'h4000, 0);
    tick(1, 0, 8'h09, 16'h0300, 0, 0);
    tick(1, 0, 8'h09, 16'h0300, 0, 0); idle(2);
    // R7 reserved mode ignored
    tick(1, 3, 8'h12, 16'h0500, 16'h0600, 16'h0700); idle(3);
    // R3 indirect, zero latency
    mem_lat = 0;
    tick(1, 2, 8'hFE, 0, 16'h2000, 16'h0010); idle(4);
    // R3/R6/R9 indirect with latency; inputs change and starts arrive mid-sequence
    mem_lat = 3;
    tick(1, 2, 8'h06, 16'h9999, 16'h3000, 16'h0123);
    for (int i = 0; i < 10; i++) tick(1, i % 2, 8'h40 + i, 16'h5555, 16'h6000 + i, 16'h0F00);
    idle(3);
    // R4 pointer high-byte address wraps FFFF -> 0000, and pointer + Y wraps
    mem_lat = 1;
    tick(1, 2, 8'h00, 0, 16'hFFFF, 16'hFFF0); idle(8);
    tick(1, 2, 8'h81, 0, 16'h0010, 16'h8000); idle(8);
    // R6 spurious rd_valid while idle has no effect
    spurious = 1; idle(4); spurious = 0;
    // R10 reset in the middle of a read
    mem_lat = 5;
    tick(1, 2, 8'h10, 0, 16'h7000, 16'h0001); idle(3);
    do_reset();
    idle(8);
    // R1 after reset recovery
    tick(1, 1, 8'hFF, 0, 16'h0000, 0); idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule